// File: doc/BRIEF.md
# IR Carrier Window Demodulator

This block sits between an infrared photodiode input and a pulse-width measurement stage. It first brings the asynchronous photodiode level into the clock domain. It then decides whether a modulated carrier burst is present by timing the interval between consecutive rising edges of the input. A programmable 16-bit divider turns the reference clock (54 MHz in the target system) into ticks, and the nominal carrier period is 16 ticks. The carrier frequency is therefore refclk / ((div_val + 1) × 16).

Each new rising edge is judged against a tolerance window around the nominal period. A 2-bit window code widens the lower and upper bounds independently. The output reads mark (1) once two consecutive intervals land inside the window. It falls back to space (0) when no acceptable edge arrives before the upper bound has elapsed. A rising edge that comes too early is discarded as a glitch and the interval measurement continues. When demodulation is switched off, the synchronised raw input is passed to the output unchanged.

Top module: `ir_carrier_demod`

## Requirements
- R1: A tick is produced once every div_val + 1 clock cycles. With div_val = 0 there is a tick on every cycle. The interval between rising edges is counted in ticks.
- R2: Bit 0 of win_sel selects the lower tolerance: 0 gives 3 ticks, 1 gives 4 ticks. Bit 1 selects the upper tolerance in the same way. An interval is accepted when it lies between 16 − lower and 16 + upper ticks inclusive. This gives 13..19 for code 0, 12..19 for code 1, 13..20 for code 2 and 12..20 for code 3.
- R3: With demod_en = 1, level_out goes to 1 after two consecutive accepted intervals, that is on the third rising edge of a valid burst. It changes 3 clock cycles after that edge reaches ir_in.
- R4: A single accepted interval (two rising edges) leaves level_out at 0.
- R5: A rising edge that arrives before the lower bound is ignored. It neither restarts the interval count nor ends the burst.
- R6: Once the interval count reaches 16 + upper tolerance ticks without an accepted edge, level_out returns to 0. The next rising edge starts a fresh measurement.
- R7: With demod_en = 0, level_out equals ir_in delayed by the two synchroniser flops, that is 2 clock cycles.
- R8: While rst_n is low, and right after it is released, level_out is 0.
- R9: Edges spaced longer than the upper bound never drive level_out to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Asynchronous photodiode level |
| demod_en | input | 1 | 1: carrier-detected output, 0: raw synchronised input |
| div_val | input | DIV_W | Tick divider value; tick period is div_val + 1 clocks |
| win_sel | input | 2 | Tolerance window code (bit 0 lower, bit 1 upper) |
| level_out | output | 1 | Demodulated mark (1) / space (0) level |

## Verification
The bench builds the block with its default parameters: a 16-bit divider, a 16-tick nominal period and a two-flop synchroniser. Most cases run with div_val = 0, so one tick equals one clock cycle. That makes every window boundary reachable by edge spacing alone, and each of the four codes is probed just inside and just outside its bounds. A second set uses div_val = 3, which shows that intervals are counted in ticks and not in clocks. The remaining cases cover the timeout, a glitch inside an interval, and the raw pass-through path.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;

  localparam int unsigned TOL_NARROW = 3;
  localparam int unsigned TOL_WIDE   = 4;

  // Bit 0 widens the lower bound, bit 1 widens the upper bound
  typedef enum logic [1:0] {
    WIN_TIGHT     = 2'd0,
    WIN_WIDE_LO   = 2'd1,
    WIN_WIDE_HI   = 2'd2,
    WIN_WIDE_BOTH = 2'd3
  } win_code_e;

  function automatic int unsigned lower_tol(win_code_e code);
    return code[0] ? TOL_WIDE : TOL_NARROW;
  endfunction

  function automatic int unsigned upper_tol(win_code_e code);
    return code[1] ? TOL_WIDE : TOL_NARROW;
  endfunction

endpackage

// File: rtl/ir_sync_edge.sv
module ir_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ir_tick_div.sv
module ir_tick_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  // ">=" lets a shrinking divider value take effect without a long wrap
  always_comb begin
    tick  = (cnt_q >= div_val);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ir_window_judge.sv
module ir_window_judge
  import ir_demod_pkg::*;
#(
  parameter int unsigned NOM_TICKS = 16,
  parameter int unsigned CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rise,
  input  logic [1:0]       win_sel,
  output logic             mark,
  output logic             armed,
  output logic             win_hit,
  output logic             early_hit,
  output logic [CNT_W-1:0] ivl
);

  logic [CNT_W-1:0] ivl_q, ivl_d, lo_lim, hi_lim, step;
  logic             armed_q, armed_d;
  logic             good_q, good_d;
  logic             mark_q, mark_d;
  logic             ivl_ce;

  always_comb begin
    lo_lim = CNT_W'(NOM_TICKS - lower_tol(win_code_e'(win_sel)));
    hi_lim = CNT_W'(NOM_TICKS + upper_tol(win_code_e'(win_sel)));
    step   = tick ? CNT_W'(1) : '0;

    early_hit = rise & armed_q & (ivl_q < lo_lim);
    win_hit   = rise & armed_q & ~early_hit & (ivl_q <= hi_lim);

    armed_d = armed_q;
    good_d  = good_q;
    mark_d  = mark_q;
    ivl_d   = ivl_q;
    ivl_ce  = 1'b0;

    if (rise && !armed_q) begin
      // first edge of a burst: open a measurement
      armed_d = 1'b1;
      good_d  = 1'b0;
      ivl_d   = step;
      ivl_ce  = 1'b1;
    end else if (win_hit) begin
      good_d  = 1'b1;
      if (good_q) mark_d = 1'b1;
      ivl_d   = step;
      ivl_ce  = 1'b1;
    end else if (armed_q && tick) begin
      if (ivl_q >= hi_lim) begin
        // upper bound elapsed without an accepted edge
        armed_d = 1'b0;
        good_d  = 1'b0;
        mark_d  = 1'b0;
        ivl_d   = '0;
      end else begin
        ivl_d   = ivl_q + 1'b1;
      end
      ivl_ce  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      good_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      good_q  <= good_d;
      mark_q  <= mark_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ivl_q <= '0;
    else if (ivl_ce) ivl_q <= ivl_d;
  end

  assign mark  = mark_q;
  assign armed = armed_q;
  assign ivl   = ivl_q;

endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod
  import ir_demod_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned NOM_TICKS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             demod_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       win_sel,
  output logic             level_out
);

  localparam int unsigned CNT_W = $clog2(NOM_TICKS + TOL_WIDE + 2);

  logic             raw_w, rise_w, tick_w;
  logic             mark_w, armed_w, hit_w, early_w;
  logic [CNT_W-1:0] ivl_w;

  ir_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ir_in),
    .lvl  (raw_w),
    .rise (rise_w)
  );

  ir_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_val(div_val),
    .tick   (tick_w)
  );

  ir_window_judge #(.NOM_TICKS(NOM_TICKS), .CNT_W(CNT_W)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .rise     (rise_w),
    .win_sel  (win_sel),
    .mark     (mark_w),
    .armed    (armed_w),
    .win_hit  (hit_w),
    .early_hit(early_w),
    .ivl      (ivl_w)
  );

  assign level_out = demod_en ? mark_w : raw_w;

endmodule

// File: rtl/ir_carrier_demod_chk.sv
module ir_carrier_demod_chk #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned NOM_TICKS   = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ir_in,
  input logic             demod_en,
  input logic [DIV_W-1:0] div_val,
  input logic             level_out,
  input logic             tick,
  input logic             mark,
  input logic             armed,
  input logic             win_hit,
  input logic             early_hit,
  input logic [CNT_W-1:0] ivl
);

  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val != '0 && $stable(div_val)) |=> !tick);

  // R3
  mark_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mark) |-> $past(win_hit));

  // R5
  early_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_hit |=> (armed && ivl >= $past(ivl)));

  // R6
  drop_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> !mark);

  // R6
  mark_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> (ivl <= CNT_W'(NOM_TICKS + 4)));

  // R7
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && !demod_en) |-> (level_out == $past(ir_in, SYNC_STAGES)));

endmodule

bind ir_carrier_demod ir_carrier_demod_chk #(
  .DIV_W(DIV_W), .NOM_TICKS(NOM_TICKS), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ir_in    (ir_in),
  .demod_en (demod_en),
  .div_val  (div_val),
  .level_out(level_out),
  .tick     (tick_w),
  .mark     (mark_w),
  .armed    (armed_w),
  .win_hit  (hit_w),
  .early_hit(early_w),
  .ivl      (ivl_w)
);

// File: tb/test_ir_carrier_demod.sv
module test_ir_carrier_demod;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        demod_en;
  logic [15:0] div_val;
  logic [1:0]  win_sel;
  logic        level_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ir_carrier_demod i_ir_carrier_demod (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_in    (ir_in),
    .demod_en (demod_en),
    .div_val  (div_val),
    .win_sel  (win_sel),
    .level_out(level_out)
  );

  // {win[18:17], div[16:13], period[12:5], pulses[4:1], expect[0]}
  localparam logic [18:0] VECS [15] = '{
    {2'd0, 4'd0, 8'd16, 4'd3, 1'b1},  // R3 nominal burst
    {2'd0, 4'd0, 8'd16, 4'd2, 1'b0},  // R4 one interval only
    {2'd0, 4'd0, 8'd13, 4'd3, 1'b1},  // R2 code 0 lower bound
    {2'd0, 4'd0, 8'd12, 4'd4, 1'b0},  // R2 code 0 below
    {2'd0, 4'd0, 8'd19, 4'd3, 1'b1},  // R2 code 0 upper bound
    {2'd0, 4'd0, 8'd20, 4'd4, 1'b0},  // R9 code 0 above
    {2'd1, 4'd0, 8'd12, 4'd3, 1'b1},  // R2 code 1 lower bound
    {2'd1, 4'd0, 8'd20, 4'd4, 1'b0},  // R9 code 1 above
    {2'd2, 4'd0, 8'd20, 4'd3, 1'b1},  // R2 code 2 upper bound
    {2'd2, 4'd0, 8'd12, 4'd4, 1'b0},  // R2 code 2 below
    {2'd3, 4'd0, 8'd12, 4'd3, 1'b1},  // R2 code 3 lower bound
    {2'd3, 4'd0, 8'd20, 4'd3, 1'b1},  // R2 code 3 upper bound
    {2'd3, 4'd0, 8'd21, 4'd4, 1'b0},  // R9 code 3 above
    {2'd0, 4'd3, 8'd64, 4'd3, 1'b1},  // R1 16 ticks of 4 clocks
    {2'd0, 4'd3, 8'd96, 4'd4, 1'b0}   // R1 24 ticks is too long
  };

  task automatic check(string tag, logic got, logic exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int per);
    ir_in = 1'b1;
    idle(3);
    ir_in = 1'b0;
    idle(per - 3);
  endtask

  // final rising edge, then sample 5 cycles after it
  task automatic last_edge();
    ir_in = 1'b1;
    idle(3);
    ir_in = 1'b0;
    idle(2);
  endtask

  initial begin
    rst_n    = 1'b0;
    ir_in    = 1'b0;
    demod_en = 1'b1;
    div_val  = '0;
    win_sel  = 2'd0;
    idle(3);
    check("R8 level during reset", level_out, 1'b0);
    rst_n = 1'b1;
    idle(2);
    check("R8 level after reset", level_out, 1'b0);

    for (int i = 0; i < 15; i++) begin
      win_sel = VECS[i][18:17];
      div_val = {12'd0, VECS[i][16:13]};
      idle(100);
      for (int k = 0; k < int'(VECS[i][4:1]) - 1; k++) pulse(int'(VECS[i][12:5]));
      last_edge();
      check($sformatf("R1 R2 R3 R4 R9 vector %0d", i), level_out, VECS[i][0]);
    end

    // R6: timeout back to space
    win_sel = 2'd0;
    div_val = '0;
    idle(100);
    pulse(16);
    pulse(16);
    last_edge();
    check("R6 mark before timeout", level_out, 1'b1);
    idle(10);
    check("R6 still mark inside bound", level_out, 1'b1);
    idle(15);
    check("R6 space after bound", level_out, 1'b0);

    // R5: glitch inside an interval does not restart measurement
    idle(100);
    pulse(16);
    ir_in = 1'b1; idle(3);
    ir_in = 1'b0; idle(3);
    ir_in = 1'b1; idle(2);
    ir_in = 1'b0; idle(8);
    last_edge();
    check("R5 early edge ignored", level_out, 1'b1);

    // R7: raw pass-through with 2-cycle latency
    idle(100);
    demod_en = 1'b0;
    idle(4);
    ir_in = 1'b1;
    idle(1);
    check("R7 rise latency 1", level_out, 1'b0);
    idle(1);
    check("R7 rise latency 2", level_out, 1'b1);
    ir_in = 1'b0;
    idle(1);
    check("R7 fall latency 1", level_out, 1'b1);
    idle(1);
    check("R7 fall latency 2", level_out, 1'b0);
    demod_en = 1'b1;
    idle(4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule